// File: doc/BRIEF.md
# Block Intensity Classifier

This block reduces one 8×8 tile of 8-bit grayscale pixels to a compact label for a block-matching image coder. Pixels arrive one per accepted cycle in raster order. Each pixel row of the tile is treated as a sub-block. The block keeps a truncated-precision mean for each row and compares every row mean with the mean of the whole tile. That gives an 8-bit classifier vector with one bit per row.

A constant folding table then maps that vector to a 5-bit class and a 3-bit symmetry tag. All eight bit-rotations of a vector land in the same class, and the tag records how far the vector is rotated away from its canonical form. The coder uses the packed 8-bit identifier to sort tiles into candidate groups, so that a search only compares tiles of the same class.

The tile is read exactly once. The identifier is issued with a one-cycle strobe directly after the last pixel. The next tile may start on that same cycle.

Top module: `fcv_block_classifier`

## Requirements
- R1: After a synchronous reset, id_vld_o is 0, id_o is 0 and cv_o is 0.
- R2: Bit k of cv_o is 1 exactly when the mean of pixel row k is greater than or equal to the tile mean, and 0 otherwise. The row mean is the sum of bits [7:3] of that row's eight pixels, an 8-bit value. The tile mean is the sum of the eight row means shifted right by 3.
- R3: Bits [2:0] of every pixel have no effect on cv_o or id_o.
- R4: id_vld_o is high for exactly one cycle, on the cycle after the 64th accepted pixel of a tile.
- R5: A cycle with pix_vld_i low is ignored: pix_i is not used and the pixel position does not advance.
- R6: id_o[7:3] is the class and id_o[2:0] is the symmetry tag. Let rot(v,r) be v rotated left by r bit places. The canonical value c is the smallest rot(cv,r) over r = 0..7. The tag is the least r for which rot(cv,r) equals c. The class is c[4:0] XOR {2'b00, c[7:5]}.
- R7: A new tile may begin on the cycle after the 64th pixel. Back-to-back tiles carry no residue from one tile to the next.
- R8: id_o and cv_o hold their values until the next strobe.
- R9: A strobed cv_o is never zero, because at least one row mean is never below the average.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_vld_i | input | 1 | Pixel accepted this cycle |
| pix_i | input | 8 | Grayscale pixel, raster order within the tile |
| cv_o | output | 8 | Classifier vector, bit k for row k |
| id_vld_o | output | 1 | One-cycle strobe for a finished tile |
| id_o | output | 8 | Identifier {class, symmetry tag} |

## Verification
Two functions can meet in one cycle. The strobe and identifier of a finished tile go out while the first pixel of the next tile is already being accumulated. Folding the last row into the comparison also happens in the same cycle as the final pixel is added. Both cases are provoked by streaming all 256 row-level bit patterns as back-to-back tiles with no idle cycle between them, and then repeating tiles with idle gaps that carry garbage pixel values. Each strobed vector and identifier is judged against an arithmetic model of the row means and the rotation fold computed in the bench. The result for a tile after a gapless boundary must match that model exactly, which shows no residue crosses the boundary.

// File: rtl/fcv_pkg.sv
package fcv_pkg;
    localparam int PIX_W   = 8;
    localparam int ROWS    = 8;
    localparam int COLS    = 8;
    localparam int KEEP_W  = 5;
    localparam int CLASS_W = 5;
    localparam int SYM_W   = 3;
    localparam int ID_W    = CLASS_W + SYM_W;
    localparam int NPIX    = ROWS * COLS;
    localparam int CNT_W   = $clog2(NPIX);
    localparam int COL_W   = $clog2(COLS);
    localparam int ROW_W   = $clog2(ROWS);
    localparam int MEAN_W  = 8;
    localparam int SUM_W   = MEAN_W + ROW_W;
    localparam int NCV     = 1 << ROWS;

    typedef logic [MEAN_W-1:0] mean_t;
    typedef logic [ROWS-1:0]   cv_t;

    typedef struct packed {
        logic [CLASS_W-1:0] cls;
        logic [SYM_W-1:0]   sym;
    } blk_id_t;

    function automatic cv_t rot_left(input cv_t v, input int r);
        cv_t o;
        for (int b = 0; b < ROWS; b++) begin
            o[(b + r) % ROWS] = v[b];
        end
        return o;
    endfunction

    function automatic blk_id_t fold_entry(input cv_t v);
        blk_id_t res;
        cv_t     best;
        cv_t     t;
        int      best_r;
        best   = v;
        best_r = 0;
        for (int r = 1; r < ROWS; r++) begin
            t = rot_left(v, r);
            if (t < best) begin
                best   = t;
                best_r = r;
            end
        end
        res.cls = best[CLASS_W-1:0] ^ {2'b00, best[ROWS-1:CLASS_W]};
        res.sym = best_r[SYM_W-1:0];
        return res;
    endfunction
endpackage

// File: rtl/fcv_row_accum.sv
module fcv_row_accum
    import fcv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_vld_i,
    input  logic [PIX_W-1:0] pix_i,
    output logic             last_o,
    output mean_t            means_now_o [ROWS]
);
    logic [CNT_W-1:0] count_q;
    mean_t            acc_q;
    mean_t            row_mean_q [ROWS];
    mean_t            acc_next;
    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row;

    assign col      = count_q[COL_W-1:0];
    assign row      = count_q[CNT_W-1:COL_W];
    assign acc_next = acc_q + mean_t'(pix_i[PIX_W-1:PIX_W-KEEP_W]);
    assign last_o   = pix_vld_i && (count_q == CNT_W'(NPIX - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            acc_q   <= '0;
            for (int k = 0; k < ROWS; k++) row_mean_q[k] <= '0;
        end else if (pix_vld_i) begin
            count_q <= count_q + 1'b1;
            if (col == COL_W'(COLS - 1)) begin
                row_mean_q[row] <= acc_next;
                acc_q           <= '0;
            end else begin
                acc_q <= acc_next;
            end
        end
    end

    for (genvar k = 0; k < ROWS; k++) begin : g_now
        assign means_now_o[k] = (row == ROW_W'(k)) ? acc_next : row_mean_q[k];

        AST_ROW_MEAN_MAX: assert property (@(posedge clk) disable iff (rst)
            row_mean_q[k] <= mean_t'(COLS * ((1 << KEEP_W) - 1))); // R3
    end

    AST_COUNT_WRAP: assert property (@(posedge clk) disable iff (rst)
        last_o |=> (count_q == '0) && (acc_q == '0)); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pix_vld_i |=> $stable(count_q) && $stable(acc_q)); // R5
endmodule

// File: rtl/fcv_compare.sv
module fcv_compare
    import fcv_pkg::*;
(
    input  mean_t means_i [ROWS],
    output cv_t   cv_o
);
    logic [SUM_W-1:0] total;
    mean_t            blk_mean;

    always_comb begin
        total = '0;
        for (int k = 0; k < ROWS; k++) begin
            total = total + SUM_W'(means_i[k]);
        end
    end

    assign blk_mean = total[SUM_W-1:ROW_W];

    for (genvar k = 0; k < ROWS; k++) begin : g_bit
        assign cv_o[k] = (means_i[k] >= blk_mean);
    end
endmodule

// File: rtl/fcv_fold_rom.sv
module fcv_fold_rom
    import fcv_pkg::*;
(
    input  cv_t     addr_i,
    output blk_id_t data_o
);
    blk_id_t table_q [NCV];

    for (genvar a = 0; a < NCV; a++) begin : g_entry
        assign table_q[a] = fold_entry(cv_t'(a));
    end

    assign data_o = table_q[addr_i];
endmodule

// File: rtl/fcv_block_classifier.sv
module fcv_block_classifier
    import fcv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_vld_i,
    input  logic [PIX_W-1:0] pix_i,
    output logic [ROWS-1:0]  cv_o,
    output logic             id_vld_o,
    output logic [ID_W-1:0]  id_o
);
    logic    last;
    mean_t   means_now [ROWS];
    cv_t     cv_now;
    blk_id_t id_now;

    fcv_row_accum u_accum (
        .clk         (clk),
        .rst         (rst),
        .pix_vld_i   (pix_vld_i),
        .pix_i       (pix_i),
        .last_o      (last),
        .means_now_o (means_now)
    );

    fcv_compare u_cmp (
        .means_i (means_now),
        .cv_o    (cv_now)
    );

    fcv_fold_rom u_rom (
        .addr_i (cv_now),
        .data_o (id_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cv_o     <= '0;
            id_o     <= '0;
            id_vld_o <= 1'b0;
        end else begin
            id_vld_o <= last;
            if (last) begin
                cv_o <= cv_now;
                id_o <= id_now;
            end
        end
    end

    AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        id_vld_o |=> !id_vld_o); // R4

    AST_CV_NONZERO: assert property (@(posedge clk) disable iff (rst)
        id_vld_o |-> (cv_o != '0)); // R9

    AST_ID_HOLD: assert property (@(posedge clk) disable iff (rst)
        !last |=> $stable(id_o) && $stable(cv_o)); // R8
endmodule

// File: tb/fcv_block_classifier_test.sv
module fcv_block_classifier_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pix_vld_i = 1'b0;
    logic [7:0] pix_i = 8'h00;
    logic [7:0] cv_o;
    logic       id_vld_o;
    logic [7:0] id_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [7:0] blk [64];
    logic       drv_last = 1'b0;
    logic [7:0] drv_cv = 8'h00;
    logic [7:0] drv_id = 8'h00;
    logic [7:0] held_cv = 8'h00;
    logic [7:0] held_id = 8'h00;
    logic       monitor_on = 1'b0;

    fcv_block_classifier uut (
        .clk       (clk),
        .rst       (rst),
        .pix_vld_i (pix_vld_i),
        .pix_i     (pix_i),
        .cv_o      (cv_o),
        .id_vld_o  (id_vld_o),
        .id_o      (id_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_cv();
        int m [8];
        int tot = 0;
        logic [7:0] v;
        for (int r = 0; r < 8; r++) begin
            m[r] = 0;
            for (int c = 0; c < 8; c++) m[r] += blk[r*8+c] / 8;
            tot += m[r];
        end
        for (int r = 0; r < 8; r++) v[r] = (m[r] >= tot / 8);
        return v;
    endfunction

    function automatic logic [7:0] model_id(input logic [7:0] v);
        int vals [8];
        int mn = 256;
        int tag = 0;
        int c;
        for (int r = 0; r < 8; r++) begin
            vals[r] = ((int'(v) << r) | (int'(v) >> (8 - r))) & 255;
        end
        for (int r = 0; r < 8; r++) if (vals[r] < mn) mn = vals[r];
        for (int r = 7; r >= 0; r--) if (vals[r] == mn) tag = r;
        c = (mn % 32) ^ (mn / 32);
        return 8'(c * 8 + tag);
    endfunction

    task automatic send_block(input int gaps);
        for (int i = 0; i < 64; i++) begin
            if (gaps != 0 && (i % 5) == 2) begin
                @(negedge clk);
                pix_vld_i = 1'b0;
                pix_i     = 8'(i * 37 + 11);
                drv_last  = 1'b0;
            end
            @(negedge clk);
            pix_vld_i = 1'b1;
            pix_i     = blk[i];
            if (i == 63) begin
                drv_cv   = model_cv();
                drv_id   = model_id(drv_cv);
                drv_last = 1'b1;
            end else begin
                drv_last = 1'b0;
            end
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        pix_vld_i = 1'b0;
        drv_last  = 1'b0;
    endtask

    always @(posedge clk) begin
        logic       e_v;
        logic [7:0] e_cv;
        logic [7:0] e_id;
        e_v  = drv_last;
        e_cv = drv_cv;
        e_id = drv_id;
        #5;
        if (monitor_on) begin
            if (e_v) begin
                check("R4 strobe", 32'(id_vld_o), 32'd1);
                check("R2 vector", 32'(cv_o), 32'(e_cv));
                check("R6 identifier", 32'(id_o), 32'(e_id));
                held_cv = e_cv;
                held_id = e_id;
            end else begin
                if (id_vld_o !== 1'b0) check("R4 no strobe", 32'(id_vld_o), 32'd0);
                if (id_o !== held_id || cv_o !== held_cv) begin
                    check("R8 hold id", 32'(id_o), 32'(held_id));
                    check("R8 hold cv", 32'(cv_o), 32'(held_cv));
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] cv_a, id_a;
        logic [31:0] seed;
        repeat (3) @(negedge clk);
        check("R1 reset vld", 32'(id_vld_o), 32'd0);
        check("R1 reset id", 32'(id_o), 32'd0);
        check("R1 reset cv", 32'(cv_o), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        monitor_on = 1'b1;

        // R7: all 256 row patterns, back-to-back, low bits varied (R3)
        for (int v = 0; v < 256; v++) begin
            for (int i = 0; i < 64; i++) begin
                blk[i] = (v[i/8] ? 8'd168 : 8'd64) + 8'((i * 7 + v) % 8);
            end
            send_block(0);
            #1;
            check("R2 pattern", 32'(drv_cv), (v == 0) ? 32'hFF : 32'(v));
        end
        go_idle();
        go_idle();

        // R5: gaps with garbage pixels
        seed = 32'h1234_5678;
        for (int b = 0; b < 24; b++) begin
            for (int i = 0; i < 64; i++) begin
                seed = seed * 32'd1103515245 + 32'd12345;
                blk[i] = seed[23:16] ^ 8'(i * (b + 3));
            end
            send_block(b % 2);
        end
        go_idle();
        go_idle();

        // R3: low bits do not matter
        for (int i = 0; i < 64; i++) blk[i] = 8'((i * 29 + 5) % 256) & 8'hF8;
        send_block(0);
        go_idle();
        #6;
        cv_a = cv_o;
        id_a = id_o;
        for (int i = 0; i < 64; i++) blk[i] = blk[i] | 8'h07;
        send_block(1);
        go_idle();
        #6;
        check("R3 low bits cv", 32'(cv_o), 32'(cv_a));
        check("R3 low bits id", 32'(id_o), 32'(id_a));
        check("R9 nonzero", 32'(cv_o != 8'h00), 32'd1);

        repeat (4) go_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule